// File: doc/BRIEF.md
# Three-Mode Security Alarm Controller

This block is the mode controller of a residential alarm. It sits in one clock domain and keeps one of three modes: Disarmed, Armed or Alarm. A user enters a code on a small set of combination keys. A separate check input asks the controller to judge the keys entered since the last check. A motion input raises the alarm while the system is armed. Every input is assumed to be a clean, debounced pulse that lasts one clock cycle. Debouncing, siren drivers and displays are handled elsewhere.

Key presses only load a short sequence register. They never change the mode by themselves. When check pulses, the stored sequence is compared against the code parameter. The mode then moves or holds, and the sequence register is emptied. A wrong code while the system is armed sends it straight to Alarm. The current mode and an alarm flag are the outputs. The whole block runs on the single system clock, and no slower clock is derived from it.

Top module: `alarm_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the controller in Disarmed and empties the sequence register. Keys pressed before the reset do not count toward a code checked after it.
- R2: The mode output uses the encoding 0 = Disarmed, 1 = Armed, 2 = Alarm, and it never takes the value 3. The alarm_on output is high exactly when the mode is Alarm.
- R3: A key press without check never changes the mode.
- R4: In Disarmed, check with the correct sequence gives Armed at the next edge. Check with a wrong sequence leaves the mode at Disarmed.
- R5: In Armed, check with a wrong sequence gives Alarm at the next edge.
- R6: In Armed or in Alarm, check with the correct sequence gives Disarmed at the next edge. Check with a wrong sequence in Alarm keeps Alarm.
- R7: In Armed, motion gives Alarm at the next edge. Motion wins over a check in the same cycle, even a correct one. Motion is ignored in Disarmed and in Alarm.
- R8: The sequence is correct when the last CODE_LEN key presses, in order, equal CODE. Earlier presses are pushed out and do not matter. Fewer than CODE_LEN presses since the last clear is always wrong. Key i is bit i-1 of key_press, and its identity is i. The first press of the code is in the most significant field of CODE. The default code is keys 2, 1, 3.
- R9: The sequence register is emptied after every check. A key press in the same cycle as check is discarded.
- R10: When several keys pulse in one cycle, only the lowest-numbered key is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| key_press | input | NUM_KEYS | One-cycle press pulses; bit i-1 is key i |
| check | input | 1 | One-cycle request to evaluate the entered sequence |
| motion | input | 1 | Motion sensor, active high |
| mode | output | 2 | Current mode: 0 Disarmed, 1 Armed, 2 Alarm |
| alarm_on | output | 1 | High while in Alarm |

## Verification
A press, check, motion or reset applied before a clock edge takes effect at that same edge. The mode and alarm_on show the result one cycle after the stimulus, and nothing is due later. The bench drives its inputs on the falling edge and samples just after the next rising edge. In that way every vector and directed step is checked in the cycle its result becomes due. The effect of a press shows up only at a later check, so the sequence state is judged through the mode that check produces.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_ARMED = 2'd1,
      MODE_ALERT = 2'd2
   } mode_e;

endpackage

// File: rtl/key_capture.sv
module key_capture #(
   parameter int NUM_KEYS = 3,
   parameter int CODE_LEN = 3,
   parameter int ID_W     = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NUM_KEYS-1:0]      key_press,
   input  logic                     clear,
   output logic [CODE_LEN*ID_W-1:0] seq_q
);

   localparam int SEQ_W = CODE_LEN * ID_W;

   logic [ID_W-1:0]  key_id;
   logic [SEQ_W-1:0] seq_next;

   // lowest-numbered key wins (R10): scan downward so the last hit is the lowest
   always_comb begin
      key_id = '0;
      for (int i = NUM_KEYS - 1; i >= 0; i--) begin
         if (key_press[i]) key_id = ID_W'(i + 1);
      end
   end

   generate
      if (CODE_LEN == 1) begin : g_single
         assign seq_next = key_id;
      end else begin : g_shift
         assign seq_next = {seq_q[SEQ_W-ID_W-1:0], key_id};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clear)
         seq_q <= '0;
      else if (key_id != '0)
         seq_q <= seq_next;
   end

   // R9: check empties the register, any press in that cycle is dropped
   p_clear_empties_r9: assert property (@(posedge clk) disable iff (rst)
      clear |=> seq_q == '0);

   // R8: an accepted press lands a nonzero identity in the newest field
   p_press_recorded_r8: assert property (@(posedge clk) disable iff (rst)
      (!clear && key_press != '0) |=> seq_q[ID_W-1:0] != '0);

   // R3: without presses or check the stored sequence holds
   p_idle_holds_r3: assert property (@(posedge clk) disable iff (rst)
      (!clear && key_press == '0) |=> $stable(seq_q));

   // R1: reset empties the register
   p_reset_clears_r1: assert property (@(posedge clk)
      rst |=> seq_q == '0);

endmodule

// File: rtl/code_match.sv
module code_match #(
   parameter int                          NUM_KEYS = 3,
   parameter int                          CODE_LEN = 3,
   parameter int                          ID_W     = 2,
   parameter logic [CODE_LEN*ID_W-1:0]    CODE     = '0
) (
   input  logic [CODE_LEN*ID_W-1:0] seq,
   output logic                     match
);

   logic [CODE_LEN-1:0] slot_ok;

   generate
      for (genvar k = 0; k < CODE_LEN; k++) begin : g_slot
         if (CODE[k*ID_W +: ID_W] == '0 || int'(CODE[k*ID_W +: ID_W]) > NUM_KEYS) begin : g_bad
            $error("code_match: code slot %0d names no existing key", k);
         end
         assign slot_ok[k] = (seq[k*ID_W +: ID_W] == CODE[k*ID_W +: ID_W]);
      end
   endgenerate

   assign match = &slot_ok;

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
   import alarm_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  check,
   input  logic  motion,
   input  logic  match,
   output mode_e mode_q
);

   mode_e mode_d;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_OFF: begin
            if (check && match) mode_d = MODE_ARMED;
         end
         MODE_ARMED: begin
            if (motion)     mode_d = MODE_ALERT;
            else if (check) mode_d = match ? MODE_OFF : MODE_ALERT;
         end
         MODE_ALERT: begin
            if (check && match) mode_d = MODE_OFF;
         end
         default: mode_d = MODE_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) mode_q <= MODE_OFF;
      else     mode_q <= mode_d;
   end

   p_reset_off_r1: assert property (@(posedge clk)
      rst |=> mode_q == MODE_OFF);

   p_legal_mode_r2: assert property (@(posedge clk) disable iff (rst)
      mode_q != mode_e'(2'd3));

   p_keys_no_effect_r3: assert property (@(posedge clk) disable iff (rst)
      (!check && !(motion && mode_q == MODE_ARMED)) |=> $stable(mode_q));

   p_arm_on_code_r4: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_OFF && check && match) |=> mode_q == MODE_ARMED);

   p_wrong_armed_r5: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_ARMED && check && !match) |=> mode_q == MODE_ALERT);

   p_disarm_alert_r6: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_ALERT && check && match) |=> mode_q == MODE_OFF);

   p_motion_armed_r7: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_ARMED && motion) |=> mode_q == MODE_ALERT);

endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
   import alarm_pkg::*;
#(
   parameter int NUM_KEYS = 3,
   parameter int CODE_LEN = 3,
   localparam int ID_W    = $clog2(NUM_KEYS + 1),
   parameter logic [CODE_LEN*ID_W-1:0] CODE = 6'b10_01_11
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_KEYS-1:0] key_press,
   input  logic                check,
   input  logic                motion,
   output logic [1:0]          mode,
   output logic                alarm_on
);

   localparam int SEQ_W = CODE_LEN * ID_W;

   generate
      if (NUM_KEYS < 1) begin : g_bad_keys
         $error("alarm_ctrl: NUM_KEYS must be at least 1");
      end
      if (CODE_LEN < 1) begin : g_bad_len
         $error("alarm_ctrl: CODE_LEN must be at least 1");
      end
   endgenerate

   logic [SEQ_W-1:0] seq;
   logic             match;
   mode_e            mode_st;

   key_capture #(
      .NUM_KEYS (NUM_KEYS),
      .CODE_LEN (CODE_LEN),
      .ID_W     (ID_W)
   ) capture_i (
      .clk       (clk),
      .rst       (rst),
      .key_press (key_press),
      .clear     (check),
      .seq_q     (seq)
   );

   code_match #(
      .NUM_KEYS (NUM_KEYS),
      .CODE_LEN (CODE_LEN),
      .ID_W     (ID_W),
      .CODE     (CODE)
   ) match_i (
      .seq   (seq),
      .match (match)
   );

   mode_fsm fsm_i (
      .clk    (clk),
      .rst    (rst),
      .check  (check),
      .motion (motion),
      .match  (match),
      .mode_q (mode_st)
   );

   assign mode     = mode_st;
   assign alarm_on = (mode_st == MODE_ALERT);

endmodule

// File: tb/alarm_ctrl_tb_top.sv
module alarm_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] key_press = '0;
   logic       check = 1'b0;
   logic       motion = 1'b0;
   logic [1:0] mode;
   logic       alarm_on;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #2 clk = ~clk;

   alarm_ctrl dut_i (
      .clk       (clk),
      .rst       (rst),
      .key_press (key_press),
      .check     (check),
      .motion    (motion),
      .mode      (mode),
      .alarm_on  (alarm_on)
   );

   // entry: {keys[2:0], check, motion, expected mode[1:0]}; code is keys 2,1,3
   localparam logic [6:0] VEC [0:38] = '{
      {3'b010,1'b0,1'b0,2'd0}, {3'b001,1'b0,1'b0,2'd0}, {3'b100,1'b0,1'b0,2'd0},
      {3'b000,1'b1,1'b0,2'd1},                              // R4 arm
      {3'b001,1'b0,1'b0,2'd1},                              // R3
      {3'b000,1'b1,1'b0,2'd2},                              // R5 wrong while armed
      {3'b010,1'b0,1'b0,2'd2}, {3'b001,1'b0,1'b0,2'd2},
      {3'b000,1'b0,1'b1,2'd2},                              // R7 motion ignored in alarm
      {3'b100,1'b0,1'b0,2'd2},
      {3'b000,1'b1,1'b0,2'd0},                              // R6 disarm from alarm
      {3'b000,1'b1,1'b0,2'd0},                              // R4 wrong in disarmed
      {3'b000,1'b0,1'b1,2'd0},                              // R7 motion ignored disarmed
      {3'b010,1'b0,1'b0,2'd0}, {3'b001,1'b0,1'b0,2'd0}, {3'b100,1'b0,1'b0,2'd0},
      {3'b000,1'b1,1'b0,2'd1},
      {3'b000,1'b0,1'b1,2'd2},                              // R7 motion while armed
      {3'b010,1'b0,1'b0,2'd2}, {3'b001,1'b0,1'b0,2'd2}, {3'b100,1'b0,1'b0,2'd2},
      {3'b000,1'b1,1'b0,2'd0},
      {3'b100,1'b0,1'b0,2'd0}, {3'b010,1'b0,1'b0,2'd0}, {3'b001,1'b0,1'b0,2'd0},
      {3'b100,1'b0,1'b0,2'd0},
      {3'b000,1'b1,1'b0,2'd1},                              // R8 extra early press
      {3'b010,1'b0,1'b0,2'd1}, {3'b001,1'b0,1'b0,2'd1}, {3'b100,1'b0,1'b0,2'd1},
      {3'b000,1'b1,1'b1,2'd2},                              // R7 motion beats check
      {3'b010,1'b0,1'b0,2'd2}, {3'b001,1'b0,1'b0,2'd2},
      {3'b100,1'b1,1'b0,2'd2},                              // R9 press with check dropped
      {3'b000,1'b1,1'b0,2'd2},                              // R9 register emptied
      {3'b010,1'b0,1'b0,2'd2},
      {3'b111,1'b0,1'b0,2'd2},                              // R10 lowest key recorded
      {3'b100,1'b0,1'b0,2'd2},
      {3'b000,1'b1,1'b0,2'd0}
   };

   task automatic expect_eq(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input logic [2:0] k, input logic c, input logic m, input logic r);
      @(negedge clk);
      key_press = k;
      check     = c;
      motion    = m;
      rst       = r;
      @(posedge clk);
      #1;
   endtask

   task automatic enter_code();
      step(3'b010, 1'b0, 1'b0, 1'b0);
      step(3'b001, 1'b0, 1'b0, 1'b0);
      step(3'b100, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 5000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 5000 cycles", cycles);
            finish_run();
         end
      end
   end

   initial begin
      step(3'b000, 1'b0, 1'b0, 1'b1);
      step(3'b000, 1'b0, 1'b0, 1'b1);
      expect_eq("R1 reset mode", int'(mode), 0);
      expect_eq("R2 reset flag", int'(alarm_on), 0);

      for (int i = 0; i < 39; i++) begin
         step(VEC[i][6:4], VEC[i][3], VEC[i][2], 1'b0);
         expect_eq($sformatf("R3-table vector %0d mode", i), int'(mode), int'(VEC[i][1:0]));
         expect_eq($sformatf("R2 vector %0d flag", i), int'(alarm_on), int'(VEC[i][1:0] == 2'd2));
      end

      // R8: too few presses while armed counts as wrong
      enter_code();
      step(3'b000, 1'b1, 1'b0, 1'b0);
      expect_eq("R4 armed again", int'(mode), 1);
      step(3'b001, 1'b0, 1'b0, 1'b0);
      step(3'b100, 1'b0, 1'b0, 1'b0);
      step(3'b000, 1'b1, 1'b0, 1'b0);
      expect_eq("R8 short code alarms", int'(mode), 2);
      expect_eq("R2 alarm flag", int'(alarm_on), 1);

      // R1: reset from Alarm
      step(3'b000, 1'b0, 1'b0, 1'b1);
      expect_eq("R1 reset from alarm", int'(mode), 0);
      expect_eq("R1 flag after reset", int'(alarm_on), 0);

      // R1: reset empties partial sequence
      step(3'b010, 1'b0, 1'b0, 1'b0);
      step(3'b001, 1'b0, 1'b0, 1'b0);
      step(3'b000, 1'b0, 1'b0, 1'b1);
      step(3'b100, 1'b0, 1'b0, 1'b0);
      step(3'b000, 1'b1, 1'b0, 1'b0);
      expect_eq("R1 sequence emptied by reset", int'(mode), 0);

      // R3 and R6: many presses while armed, then disarm from Armed
      enter_code();
      step(3'b000, 1'b1, 1'b0, 1'b0);
      for (int j = 0; j < 6; j++) begin
         step(3'(1 << (j % 3)), 1'b0, 1'b0, 1'b0);
         expect_eq("R3 presses keep armed", int'(mode), 1);
      end
      enter_code();
      step(3'b000, 1'b1, 1'b0, 1'b0);
      expect_eq("R6 disarm from armed", int'(mode), 0);

      step(3'b000, 1'b0, 1'b0, 1'b0);
      finish_run();
   end

endmodule